// File: doc/BRIEF.md
# Fault-Injectable Word RAM

A small synthesizable word-organised RAM with a synchronous read/write port and a static fault-injection port. It is the device under test for a memory self-test engine. It lets a test sequence be run against a memory that carries one known defect, so that the sequence can be shown to catch that defect. A 5-bit fault code selects one defect type. A victim word address and bit index name the cell that misbehaves. An aggressor word address and bit index name the cell whose state or transitions trigger coupling-type defects.

The memory bends its write, read and hold behaviour to follow the selected defect. The defects fall into three groups. Single-cell defects are stuck bits and blocked transitions. Two-cell coupling defects are state, idempotent, inversion, incorrect-read and read-destructive. The last is a retention defect that flips the victim after it has sat unaccessed for a set number of cycles. The fault configuration is meant to be set while reset is held and kept static during a test. Synchronous reset clears every word.

Top module: `fault_ram`

## Requirements
- R1: With fault code 0 (none), a write stores `wdata` at `addr` on the clock edge where `we` is high. A read with `re` high and `we` low loads `rdata` with the addressed word on that edge, and `rdata` holds between reads. When `we` and `re` are both high, only the write takes place and `rdata` keeps its value.
- R2: Code 1 (stuck-at-0) and code 2 (stuck-at-1) make the victim bit store and return 0 or 1 respectively, whatever is written.
- R3: Code 3 blocks a 0-to-1 write on the victim bit, and code 4 blocks a 1-to-0 write. All other writes to the victim and to the rest of the word act normally.
- R4: Codes 5 to 8 are state coupling. With k = code-5, the condition is that the aggressor holds state k[1], and the victim is then forced to value k[0]. The victim is forced on every cycle in which the aggressor holds that state, including over a write to the victim.
- R5: Codes 9 to 12 are idempotent coupling. With k = code-9, a rising (k[1]=0) or falling (k[1]=1) write transition of the aggressor forces the victim to k[0]. There is no effect without that transition.
- R6: Code 13 (rising) and code 14 (falling) invert the stored victim bit when the aggressor makes that write transition.
- R7: Codes 15 and 16 are incorrect-read. A read of the victim word while the aggressor holds 0 (code 15) or 1 (code 16) returns the victim bit inverted. The stored victim bit is left unchanged.
- R8: Codes 17 and 18 are read-destructive. A read of the victim word while the aggressor holds 0 (code 17) or 1 (code 18) inverts the stored victim bit and returns the inverted value.
- R9: Code 19 is retention. After RET_LIMIT consecutive clock edges with no read or write to the victim word, the stored victim bit inverts and the idle count restarts. Any access to the victim word restarts the count.
- R10: Coupling effects triggered by an aggressor write take effect on that same clock edge. This holds whether the victim address is below or above the aggressor address.
- R11: Synchronous reset clears every word and `rdata` to zero. Codes 20 to 31 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| fault_sel | input | 5 | Fault code (see requirements) |
| vic_addr | input | ADDR_W | Victim word address |
| vic_bit | input | log2(DATA_W) | Victim bit index |
| agg_addr | input | ADDR_W | Aggressor word address |
| agg_bit | input | log2(DATA_W) | Aggressor bit index |

## Verification
Every defect lives in the stored victim bit, the read-return path or the idle counter. A wrong internal state is therefore only visible once the victim word is read. Each scenario reads the victim one edge after the triggering write and compares against a value worked out from the fault code.

Read-only and destructive read defects are told apart by a second read after the aggressor condition has been removed. A wrong idle count shows up as a retention flip that is early or missing. It is probed with reads placed well short of the limit and well past it.

// File: rtl/fram_pkg.sv
package fram_pkg;

    localparam int FSEL_W = 5;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_STUCK,
        CLS_TRANS,
        CLS_STATE,
        CLS_IDEM,
        CLS_INV,
        CLS_RDIR,
        CLS_RDDS,
        CLS_RET
    } fcls_e;

    // cond: aggressor state, transition direction (0 rising / 1 falling),
    //       or blocked source value for transition faults.
    // val : value forced onto the victim.
    typedef struct packed {
        fcls_e cls;
        logic  cond;
        logic  val;
    } fcfg_t;

    function automatic fcfg_t decode_fault(input logic [FSEL_W-1:0] code);
        fcfg_t c;
        logic [FSEL_W-1:0] k;
        c.cls  = CLS_NONE;
        c.cond = 1'b0;
        c.val  = 1'b0;
        k      = '0;
        if (code == 5'd1 || code == 5'd2) begin
            c.cls = CLS_STUCK;
            c.val = (code == 5'd2);
        end else if (code == 5'd3 || code == 5'd4) begin
            c.cls  = CLS_TRANS;
            c.cond = (code == 5'd4);
        end else if (code >= 5'd5 && code <= 5'd8) begin
            k      = code - 5'd5;
            c.cls  = CLS_STATE;
            c.cond = k[1];
            c.val  = k[0];
        end else if (code >= 5'd9 && code <= 5'd12) begin
            k      = code - 5'd9;
            c.cls  = CLS_IDEM;
            c.cond = k[1];
            c.val  = k[0];
        end else if (code == 5'd13 || code == 5'd14) begin
            c.cls  = CLS_INV;
            c.cond = (code == 5'd14);
        end else if (code == 5'd15 || code == 5'd16) begin
            c.cls  = CLS_RDIR;
            c.cond = (code == 5'd16);
        end else if (code == 5'd17 || code == 5'd18) begin
            c.cls  = CLS_RDDS;
            c.cond = (code == 5'd18);
        end else if (code == 5'd19) begin
            c.cls = CLS_RET;
        end
        return c;
    endfunction

endpackage

// File: rtl/fram_store.sv
module fram_store #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4,
    localparam int BIT_W = $clog2(DATA_W),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fix_en,
    input  logic              fix_val,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [BIT_W-1:0]  vic_bit,
    input  logic [ADDR_W-1:0] agg_addr,
    input  logic [BIT_W-1:0]  agg_bit,
    output logic [DATA_W-1:0] rd_word,
    output logic              vic_q,
    output logic              agg_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Normal word write first, victim override second: the later
    // nonblocking assignment to the victim bit takes precedence.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_en) mem[addr] <= wdata;
            if (fix_en) mem[vic_addr][vic_bit] <= fix_val;
        end
    end

    assign rd_word = mem[addr];
    assign vic_q   = mem[vic_addr][vic_bit];
    assign agg_q   = mem[agg_addr][agg_bit];

endmodule

// File: rtl/fram_retention.sv
module fram_retention #(
    parameter int RET_LIMIT = 20,
    localparam int CNT_W = $clog2(RET_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic access,
    output logic expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RET_LIMIT - 1);

    logic [CNT_W-1:0] idle_cnt;

    assign expire = enable && !access && (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable || access || expire) idle_cnt <= '0;
        else                                    idle_cnt <= idle_cnt + 1'b1;
    end

    assert_idle_bound_R9: assert property (@(posedge clk) disable iff (rst)
        idle_cnt < CNT_W'(RET_LIMIT));

    assert_access_restart_R9: assert property (@(posedge clk) disable iff (rst)
        access |=> (idle_cnt == '0));

endmodule

// File: rtl/fram_fault_logic.sv
module fram_fault_logic
    import fram_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  fcfg_t             cfg,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [BIT_W-1:0]  vic_bit,
    input  logic [ADDR_W-1:0] agg_addr,
    input  logic [BIT_W-1:0]  agg_bit,
    input  logic              vic_q,
    input  logic              agg_q,
    input  logic              ret_expire,
    output logic              fix_en,
    output logic              fix_val,
    output logic              rd_val
);

    logic vic_wr_hit, agg_wr_hit, rd_hit;
    logic v_wr, a_next, rise, fall, edge_hit, agg_match;

    always_comb begin
        vic_wr_hit = we && (addr == vic_addr);
        agg_wr_hit = we && (addr == agg_addr);
        rd_hit     = re && !we && (addr == vic_addr);
        v_wr       = vic_wr_hit ? wdata[vic_bit] : vic_q;
        a_next     = agg_wr_hit ? wdata[agg_bit] : agg_q;
        rise       = !agg_q && a_next;
        fall       = agg_q && !a_next;
        edge_hit   = cfg.cond ? fall : rise;
        agg_match  = (agg_q == cfg.cond);

        fix_val = v_wr;
        rd_val  = vic_q;
        unique case (cfg.cls)
            CLS_STUCK: begin
                fix_val = cfg.val;
                rd_val  = cfg.val;
            end
            CLS_TRANS: begin
                if (vic_wr_hit && vic_q == cfg.cond && wdata[vic_bit] != cfg.cond)
                    fix_val = vic_q;
            end
            CLS_STATE: begin
                if (a_next == cfg.cond) fix_val = cfg.val;
            end
            CLS_IDEM: begin
                if (edge_hit) fix_val = cfg.val;
            end
            CLS_INV: begin
                if (edge_hit) fix_val = !v_wr;
            end
            CLS_RDIR: begin
                if (rd_hit && agg_match) rd_val = !vic_q;
            end
            CLS_RDDS: begin
                if (rd_hit && agg_match) begin
                    rd_val  = !vic_q;
                    fix_val = !vic_q;
                end
            end
            CLS_RET: begin
                if (ret_expire) fix_val = !vic_q;
            end
            default: ;
        endcase
        fix_en = (cfg.cls != CLS_NONE);
    end

endmodule

// File: rtl/fault_ram.sv
module fault_ram
    import fram_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 4,
    parameter int RET_LIMIT = 20,
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [4:0]        fault_sel,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [BIT_W-1:0]  vic_bit,
    input  logic [ADDR_W-1:0] agg_addr,
    input  logic [BIT_W-1:0]  agg_bit
);

    fcfg_t             cfg;
    logic              cfg_val, cfg_cond;
    logic [DATA_W-1:0] rd_word, rd_mux;
    logic              vic_q, agg_q, fix_en, fix_val, rd_val;
    logic              ret_expire, vic_access;

    assign cfg        = decode_fault(fault_sel);
    assign cfg_val    = cfg.val;
    assign cfg_cond   = cfg.cond;
    assign vic_access = (we || re) && (addr == vic_addr);

    fram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(we), .addr(addr), .wdata(wdata),
        .fix_en(fix_en), .fix_val(fix_val),
        .vic_addr(vic_addr), .vic_bit(vic_bit),
        .agg_addr(agg_addr), .agg_bit(agg_bit),
        .rd_word(rd_word), .vic_q(vic_q), .agg_q(agg_q)
    );

    fram_retention #(.RET_LIMIT(RET_LIMIT)) u_ret (
        .clk(clk), .rst(rst), .enable(cfg.cls == CLS_RET),
        .access(vic_access), .expire(ret_expire)
    );

    fram_fault_logic #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_logic (
        .cfg(cfg), .we(we), .re(re), .addr(addr), .wdata(wdata),
        .vic_addr(vic_addr), .vic_bit(vic_bit),
        .agg_addr(agg_addr), .agg_bit(agg_bit),
        .vic_q(vic_q), .agg_q(agg_q), .ret_expire(ret_expire),
        .fix_en(fix_en), .fix_val(fix_val), .rd_val(rd_val)
    );

    always_comb begin
        rd_mux = rd_word;
        if (addr == vic_addr) rd_mux[vic_bit] = rd_val;
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata <= '0;
        else if (re && !we)  rdata <= rd_mux;
    end

    assert_plain_read_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg.cls == CLS_NONE && re && !we) |=> rdata == $past(rd_word));

    assert_write_wins_R1: assert property (@(posedge clk) disable iff (rst)
        (we) |=> $stable(rdata));

    assert_stuck_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.cls == CLS_STUCK) |=> vic_q == $past(cfg_val));

    assert_trans_block_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.cls == CLS_TRANS && we && addr == vic_addr && vic_q == cfg_cond)
        |=> vic_q == $past(cfg_cond));

    assert_ird_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.cls == CLS_RDIR && re && !we) |=> $stable(vic_q));

    assert_rdd_flips_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.cls == CLS_RDDS && re && !we && addr == vic_addr && agg_q == cfg_cond)
        |=> vic_q != $past(vic_q));

endmodule

// File: tb/test_fault_ram.sv
module test_fault_ram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int RET = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0, re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [4:0]    fault_sel = '0;
    logic [AW-1:0] vic_addr = 3'd2, agg_addr = 3'd5;
    logic [1:0]    vic_bit = 2'd1, agg_bit = 2'd3;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_ram #(.ADDR_W(AW), .DATA_W(DW), .RET_LIMIT(RET)) i_fault_ram (
        .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fault_sel(fault_sel), .vic_addr(vic_addr),
        .vic_bit(vic_bit), .agg_addr(agg_addr), .agg_bit(agg_bit)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic setup(input logic [4:0] code, input logic [AW-1:0] va, input logic [1:0] vb,
                         input logic [AW-1:0] aa, input logic [1:0] ab);
        @(negedge clk);
        rst = 1'b1; we = 1'b0; re = 1'b0;
        fault_sel = code; vic_addr = va; vic_bit = vb; agg_addr = aa; agg_bit = ab;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        chk(req, rdata, exp);
    endtask

    task automatic t_reset;
        setup(5'd0, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd3, 4'hA);
        wr(3'd7, 4'hF);
        setup(5'd23, 3'd2, 2'd1, 3'd5, 2'd3);
        chk("R11 rdata after reset", rdata, 4'h0);
        rd("R11 word cleared", 3'd3, 4'h0);
        rd("R11 word cleared", 3'd7, 4'h0);
        wr(3'd2, 4'hF);
        rd("R11 unused code acts as none", 3'd2, 4'hF);
    endtask

    task automatic t_normal;
        setup(5'd0, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd3, 4'hA);
        wr(3'd4, 4'h5);
        rd("R1 read back", 3'd3, 4'hA);
        rd("R1 read back", 3'd4, 4'h5);
        @(negedge clk);
        we = 1'b1; re = 1'b1; addr = 3'd3; wdata = 4'h6;
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        chk("R1 write wins, rdata held", rdata, 4'h5);
        rd("R1 write took effect", 3'd3, 4'h6);
    endtask

    task automatic t_stuck;
        setup(5'd2, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        rd("R2 stuck-at-1", 3'd2, 4'h2);
        setup(5'd1, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'hF);
        rd("R2 stuck-at-0", 3'd2, 4'hD);
    endtask

    task automatic t_trans;
        setup(5'd3, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        wr(3'd2, 4'hF);
        rd("R3 rising blocked", 3'd2, 4'hD);
        setup(5'd4, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'hF);
        rd("R3 rising allowed under down fault", 3'd2, 4'hF);
        wr(3'd2, 4'h0);
        rd("R3 falling blocked", 3'd2, 4'h2);
    endtask

    task automatic t_state;
        setup(5'd8, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        rd("R4 aggressor 0 no force", 3'd2, 4'h0);
        wr(3'd5, 4'h8);
        rd("R4 aggressor 1 forces 1", 3'd2, 4'h2);
        wr(3'd2, 4'h0);
        rd("R4 force over victim write", 3'd2, 4'h2);
        setup(5'd5, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'hF);
        rd("R4 aggressor 0 forces 0", 3'd2, 4'hD);
    endtask

    task automatic t_idem;
        setup(5'd10, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        wr(3'd5, 4'h8);
        rd("R5 rising forces 1", 3'd2, 4'h2);
        wr(3'd2, 4'h0);
        wr(3'd5, 4'h0);
        rd("R5 falling no effect", 3'd2, 4'h0);
        setup(5'd11, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'hF);
        wr(3'd5, 4'h8);
        rd("R5 rising no effect", 3'd2, 4'hF);
        wr(3'd5, 4'h0);
        rd("R5 falling forces 0", 3'd2, 4'hD);
    endtask

    task automatic t_inv;
        setup(5'd14, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h2);
        wr(3'd5, 4'h8);
        rd("R6 rising no flip", 3'd2, 4'h2);
        wr(3'd5, 4'h0);
        rd("R6 falling flips", 3'd2, 4'h0);
        setup(5'd13, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        wr(3'd5, 4'h8);
        rd("R6 rising flips", 3'd2, 4'h2);
    endtask

    task automatic t_ird;
        setup(5'd16, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h2);
        rd("R7 no match plain read", 3'd2, 4'h2);
        wr(3'd5, 4'h8);
        rd("R7 inverted read", 3'd2, 4'h0);
        rd("R7 inverted read again", 3'd2, 4'h0);
        wr(3'd5, 4'h0);
        rd("R7 stored value kept", 3'd2, 4'h2);
    endtask

    task automatic t_drd;
        setup(5'd17, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h2);
        rd("R8 destructive read returns flipped", 3'd2, 4'h0);
        wr(3'd5, 4'h8);
        rd("R8 stored value destroyed", 3'd2, 4'h0);
    endtask

    task automatic t_order;
        // Aggressor below victim: victim word 6 bit 2, aggressor word 1 bit 0.
        setup(5'd13, 3'd6, 2'd2, 3'd1, 2'd0);
        wr(3'd6, 4'h0);
        wr(3'd1, 4'h1);
        rd("R10 inversion, aggressor below", 3'd6, 4'h4);
        setup(5'd9, 3'd6, 2'd2, 3'd1, 2'd0);
        wr(3'd6, 4'hF);
        wr(3'd1, 4'h1);
        rd("R10 idempotent, aggressor below", 3'd6, 4'hB);
        setup(5'd12, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h0);
        wr(3'd5, 4'h8);
        wr(3'd5, 4'h0);
        rd("R10 idempotent, aggressor above", 3'd2, 4'h2);
    endtask

    task automatic t_ret;
        setup(5'd19, 3'd2, 2'd1, 3'd5, 2'd3);
        wr(3'd2, 4'h2);
        repeat (RET - 6) @(negedge clk);
        rd("R9 no flip before limit", 3'd2, 4'h2);
        wr(3'd5, 4'h8);
        repeat (RET + 5) @(negedge clk);
        rd("R9 flip after idle limit", 3'd2, 4'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_normal;
        t_stuck;
        t_trans;
        t_state;
        t_idem;
        t_inv;
        t_ird;
        t_drd;
        t_order;
        t_ret;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule